// File: doc/BRIEF.md
# Binary-Operand Negacyclic Multiply-Accumulate Engine

This block forms D = A·B + C in the ring of polynomials with W-bit coefficients modulo 2^W, reduced modulo x^N + 1. Operand A carries full W-bit coefficients. Operand B is binary, one bit per coefficient. Operand C is an addend polynomial. Because every coefficient of B is 0 or 1, no multiplier is needed. A shift register holds A and multiplies it by x once per step. An accumulator bank starts out holding C. On each step it adds in the current multiple of A whenever the matching bit of B is set.

A host pulses `start`. It then streams N beats, and beat k carries coefficient k of A, bit k of B and coefficient k of C. The block then spends N cycles on the accumulation. After that it streams the N result coefficients, lowest degree first, under a valid/ready handshake, and pulses `done`. The defaults are N = 256 and W = 8, so all coefficient arithmetic is plain 8-bit wraparound.

Top module: `nmac_top`

## Requirements
- R1: With random A, B and C, the output coefficients equal A·B + C with coefficients taken modulo 2^W and exponents folded through x^N = -1.
- R2: While reset is held, and in the cycle after it is released, `in_ready`, `out_valid`, `busy` and `done` are all 0.
- R3: The cycle after a `start` pulse seen while idle, `in_ready` is 1. A beat is taken only on a cycle where both `in_valid` and `in_ready` are 1. Beat k (k = 0 first) supplies `in_a` = coefficient k of A, `in_b` = bit k of B and `in_c` = coefficient k of C. Cycles with `in_valid` low are skipped without loss.
- R4: `start` has no effect while `busy` is 1. A pulse during loading or computing neither restarts the load nor changes the result or its timing.
- R5: After the edge that takes the last input beat, `in_ready` is 0. `out_valid` first reads 1 exactly N clock cycles later.
- R6: Results leave lowest degree first, one per cycle on which `out_valid` and `out_ready` are both 1. While `out_ready` is 0, `out_valid` stays 1 and `out_coef` holds its value.
- R7: `done` is 1 for exactly one cycle. That cycle directly follows the edge that takes the last result. In the same cycle `busy` reads 0.
- R8: With B = x^(N-1), the output is D_k = C_k - A_(k+1) for k < N-1, and D_(N-1) = C_(N-1) + A_0. Each step moves coefficient N-1 of the rotated A into position 0 negated.
- R9: With B = 0 the output equals C. With B = 1 (only bit 0 set) the output equals A + C coefficient by coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when idle |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts input beats |
| in_a | input | W | Coefficient of A for this beat |
| in_b | input | 1 | Bit of B for this beat |
| in_c | input | W | Coefficient of C for this beat |
| out_valid | output | 1 | Result coefficient present |
| out_ready | input | 1 | Host takes the result coefficient |
| out_coef | output | W | Result coefficient, lowest degree first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the final result is taken |

## Verification
A wrong step in the rotation shows up only in the results. A dropped negation at the wrap or an off-by-one shift corrupts exactly the coefficients that the corner operands B = 1 and B = x^(N-1) expose, and these become visible as soon as draining begins, N cycles after loading. A control count that is off by one moves the rise of `out_valid` or the `done` pulse by a cycle, so the bench times both against the handshake edges. A B bit or C coefficient that lands in the wrong slot gives a mismatch at a predictable output index in the random and B = 0 runs.

// File: rtl/nmac_pkg.sv
package nmac_pkg;

    localparam int unsigned DEF_N = 256;
    localparam int unsigned DEF_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_CALC  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    typedef struct packed {
        logic load_shift;
        logic calc_step;
        logic drain_shift;
    } ctl_t;

endpackage

// File: rtl/nmac_ctrl.sv
module nmac_ctrl
    import nmac_pkg::*;
#(
    parameter int unsigned N = DEF_N
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic busy,
    output logic done,
    output ctl_t ctl
);
    localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOAD;
                        cnt   <= '0;
                    end
                end
                PH_LOAD: begin
                    if (in_valid) begin
                        if (at_last) begin
                            phase <= PH_CALC;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_CALC: begin
                    if (at_last) begin
                        phase <= PH_DRAIN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DRAIN: begin
                    if (out_ready) begin
                        if (at_last) begin
                            phase <= PH_IDLE;
                            cnt   <= '0;
                            done  <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        in_ready        = (phase == PH_LOAD);
        out_valid       = (phase == PH_DRAIN);
        busy            = (phase != PH_IDLE);
        ctl.load_shift  = in_valid && in_ready;
        ctl.calc_step   = (phase == PH_CALC);
        ctl.drain_shift = out_valid && out_ready;
    end

    // R7: done never lasts two cycles
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: done only follows an accepted output
    assert_done_after_take_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_valid && out_ready));

    // R5: results appear only after the compute phase
    assert_drain_after_calc_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(phase == PH_CALC));

    // R4: start during loading leaves the beat count untouched
    assert_start_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && start && !in_valid) |=> (phase == PH_LOAD && $stable(cnt)));

endmodule

// File: rtl/nmac_rotreg.sv
module nmac_rotreg
    import nmac_pkg::*;
#(
    parameter int unsigned N = DEF_N,
    parameter int unsigned W = DEF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_shift,
    input  logic                calc_step,
    input  logic [W-1:0]        in_coef,
    output logic [N-1:0][W-1:0] a_vec
);
    logic [N-1:0][W-1:0] a_q;

    for (genvar j = 0; j < N; j++) begin : g_cell
        logic [W-1:0] load_src;
        logic [W-1:0] rot_src;

        if (j == N - 1) begin : g_top
            assign load_src = in_coef;
        end else begin : g_mid
            assign load_src = a_q[j+1];
        end

        if (j == 0) begin : g_wrap
            assign rot_src = W'(-a_q[N-1]);
        end else begin : g_up
            assign rot_src = a_q[j-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                a_q[j] <= '0;
            end else if (load_shift) begin
                a_q[j] <= load_src;
            end else if (calc_step) begin
                a_q[j] <= rot_src;
            end
        end
    end

    assign a_vec = a_q;

    // R8: wrapped coefficient comes back negated
    assert_wrap_negates_R8: assert property (@(posedge clk) disable iff (rst)
        (calc_step && !load_shift) |=> (a_q[0] == W'(-$past(a_q[N-1]))));

endmodule

// File: rtl/nmac_accbank.sv
module nmac_accbank
    import nmac_pkg::*;
#(
    parameter int unsigned N = DEF_N,
    parameter int unsigned W = DEF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_shift,
    input  logic                calc_step,
    input  logic                drain_shift,
    input  logic                sel_bit,
    input  logic [W-1:0]        in_coef,
    input  logic [N-1:0][W-1:0] a_vec,
    output logic [W-1:0]        out_coef
);
    logic [N-1:0][W-1:0] acc_q;

    for (genvar j = 0; j < N; j++) begin : g_slot
        logic [W-1:0] shift_src;
        logic [W-1:0] drain_src;
        logic [W-1:0] sum;

        if (j == N - 1) begin : g_top
            assign shift_src = in_coef;
            assign drain_src = '0;
        end else begin : g_mid
            assign shift_src = acc_q[j+1];
            assign drain_src = acc_q[j+1];
        end

        assign sum = acc_q[j] + a_vec[j];

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[j] <= '0;
            end else if (load_shift) begin
                acc_q[j] <= shift_src;
            end else if (calc_step && sel_bit) begin
                acc_q[j] <= sum;
            end else if (drain_shift) begin
                acc_q[j] <= drain_src;
            end
        end
    end

    assign out_coef = acc_q[0];

endmodule

// File: rtl/nmac_top.sv
module nmac_top
    import nmac_pkg::*;
#(
    parameter int unsigned N = DEF_N,
    parameter int unsigned W = DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_a,
    input  logic         in_b,
    input  logic [W-1:0] in_c,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_coef,
    output logic         busy,
    output logic         done
);
    ctl_t                ctl;
    logic [N-1:0]        b_q;
    logic [N-1:0][W-1:0] a_vec;

    nmac_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .busy      (busy),
        .done      (done),
        .ctl       (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else if (ctl.load_shift) begin
            b_q <= {in_b, b_q[N-1:1]};
        end else if (ctl.calc_step) begin
            b_q <= {1'b0, b_q[N-1:1]};
        end
    end

    nmac_rotreg #(.N(N), .W(W)) u_rot (
        .clk        (clk),
        .rst        (rst),
        .load_shift (ctl.load_shift),
        .calc_step  (ctl.calc_step),
        .in_coef    (in_a),
        .a_vec      (a_vec)
    );

    nmac_accbank #(.N(N), .W(W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .load_shift  (ctl.load_shift),
        .calc_step   (ctl.calc_step),
        .drain_shift (ctl.drain_shift),
        .sel_bit     (b_q[0]),
        .in_coef     (in_c),
        .a_vec       (a_vec),
        .out_coef    (out_coef)
    );

    // R6: a stalled result holds
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_coef)));

    // R3: input and output phases never overlap
    assert_phase_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

endmodule

// File: tb/nmac_top_tb.sv
`timescale 1ns/1ps
module nmac_top_tb;
    localparam int N = 256;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_a = '0;
    logic         in_b = 1'b0;
    logic [W-1:0] in_c = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_coef;
    logic         busy;
    logic         done;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] opa [N];
    logic         opb [N];
    logic [W-1:0] opc [N];
    logic [W-1:0] expd[N];
    logic [W-1:0] got [N];

    always #2.5 clk = ~clk;

    nmac_top #(.N(N), .W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_ready(out_ready), .out_coef(out_coef),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model();
        for (int k = 0; k < N; k++) expd[k] = opc[k];
        for (int i = 0; i < N; i++) begin
            if (opb[i]) begin
                for (int j = 0; j < N; j++) begin
                    if (i + j < N) expd[i+j]     = expd[i+j] + opa[j];
                    else           expd[i+j-N]   = expd[i+j-N] - opa[j];
                end
            end
        end
    endtask

    // Full operation: start, load, wait, drain; timing checks inline.
    task automatic run_op(input bit gaps, input bit stall, input bit noise);
        int lat;
        logic [W-1:0] held;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(in_ready === 1'b1, "R3", "in_ready after start", in_ready, 1);
        for (int k = 0; k < N; k++) begin
            if (gaps && (k % 7 == 3)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_a = opa[k];
            in_b = opb[k];
            in_c = opc[k];
            start = noise && (k == N / 2);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        start = 1'b0;
        check(in_ready === 1'b0, "R5", "in_ready after last beat", in_ready, 0);
        lat = 0;
        while (!out_valid && lat < 4 * N) begin
            start = noise && (lat == 3);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(lat == N, "R5", "compute latency", lat, N);
        for (int k = 0; k < N; k++) begin
            if (stall && (k % 5 == 2)) begin
                out_ready = 1'b0;
                held = out_coef;
                @(negedge clk);
                if (k == 2)
                    check(out_valid === 1'b1 && out_coef === held, "R6",
                          "stalled result held", out_coef, held);
            end
            out_ready = 1'b1;
            got[k] = out_coef;
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(done === 1'b1 && busy === 1'b0, "R7", "done after last take",
              {done, busy}, 2);
        @(negedge clk);
        check(done === 1'b0, "R7", "done one cycle", done, 0);
    endtask

    task automatic compare(input string req);
        int bad;
        int idx;
        bad = 0;
        idx = 0;
        model();
        for (int k = 0; k < N; k++) begin
            if (got[k] !== expd[k] && bad == 0) idx = k;
            if (got[k] !== expd[k]) bad++;
        end
        check(bad == 0, req, $sformatf("coefficient %0d", idx), got[idx], expd[idx]);
    endtask

    task automatic fill_random();
        for (int k = 0; k < N; k++) begin
            opa[k] = W'($urandom);
            opb[k] = 1'($urandom);
            opc[k] = W'($urandom);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check({in_ready, out_valid, busy, done} === 4'b0, "R2", "outputs in reset",
              {in_ready, out_valid, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({in_ready, out_valid, busy, done} === 4'b0, "R2", "outputs after reset",
              {in_ready, out_valid, busy, done}, 0);
    endtask

    task automatic test_random();
        for (int r = 0; r < 3; r++) begin
            fill_random();
            run_op(r == 1, r == 2, 1'b0);
            compare("R1");
        end
    endtask

    task automatic test_b_zero();
        fill_random();
        for (int k = 0; k < N; k++) opb[k] = 1'b0;
        run_op(1'b0, 1'b0, 1'b0);
        compare("R9");
    endtask

    task automatic test_b_one();
        fill_random();
        for (int k = 0; k < N; k++) opb[k] = (k == 0);
        run_op(1'b1, 1'b0, 1'b0);
        compare("R9");
    endtask

    task automatic test_b_top();
        fill_random();
        for (int k = 0; k < N; k++) opb[k] = (k == N - 1);
        run_op(1'b0, 1'b1, 1'b0);
        compare("R8");
        check(got[0] === W'(opc[0] - opa[1]), "R8", "D0 = C0 - A1", got[0],
              W'(opc[0] - opa[1]));
        check(got[N-1] === W'(opc[N-1] + opa[0]), "R8", "top = C + A0", got[N-1],
              W'(opc[N-1] + opa[0]));
    endtask

    task automatic test_start_noise();
        fill_random();
        run_op(1'b1, 1'b1, 1'b1);
        compare("R4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_random();
        test_b_zero();
        test_b_one();
        test_b_top();
        test_start_noise();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule